// File: doc/BRIEF.md
# Write-Verifying Multi-Channel Memory Controller

This block sits between one request port of an on-chip interconnect and several independent memory-array channels. Requests carry an address, a read/write flag and a tag. They wait in an address queue, and the payload of every write waits in a second queue of its own. The low-order word-address bits choose the channel. The remaining upper bits form the address inside that channel. Every channel owns one read register, which captures the word whenever that channel strobes data back. A multiplexer picks the register of the active channel for the response.

A write is never trusted blindly. Once the channel accepts it, the controller reads the same location back and compares the word with the queued payload. The payload leaves its queue only when the two agree. On a mismatch the write is sent again, up to a parameter number of reissues. After the last reissue fails, an error response carries the tag of the request.

Requests are served strictly in arrival order, with one request in flight at a time. A read that follows a write to the same location therefore never overtakes the write's verification.

Top module: `wv_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and every bit of `ch_valid` is 0.
- R2: The target channel is `(addr >> WOFF) % NCH`, where WOFF = log2(DW/8). The in-channel address on `ch_addr` is `addr >> (WOFF + log2(NCH))`, so the byte-offset bits have no effect. At most one `ch_valid` bit is high at a time.
- R3: Once a `ch_valid` bit rises, it stays high with `ch_addr` and `ch_write` unchanged until the matching `ch_ready` bit is seen high at a clock edge.
- R4: A read response has `rsp_kind` = 2'b00, echoes the request tag, and returns the word that the addressed channel delivered with its `ch_dvalid` strobe. Responses come out one per request, in request order, each as a one-cycle pulse.
- R5: Every accepted write handshake on a channel is followed by a read handshake to the same channel and in-channel address, with no other write in between.
- R6: When the read-back word equals the queued payload, the write ends with `rsp_kind` = 2'b01 and its tag.
- R7: On a read-back mismatch the write is reissued. A request makes at most MAX_RETRY+1 write attempts, and a request whose first k attempts fail makes min(k, MAX_RETRY)+1 attempts.
- R8: When the attempt after the last permitted reissue still mismatches, the write ends with `rsp_kind` = 2'b10 and its tag, and its payload is dropped.
- R9: `req_ready` is 0 whenever the address queue holds AQ_DEPTH entries or the write-data queue holds WQ_DEPTH entries.
- R10: A read issued after a write to the same location returns the word that write left in the array, including a corrupted word after a write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_tag | input | TW | Tag echoed on the response |
| req_wdata | input | DW | Write payload |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | 00 read, 01 write verified, 10 write error |
| rsp_tag | output | TW | Tag of the completed request |
| rsp_rdata | output | DW | Read word (read responses) |
| ch_valid | output | NCH | Per-channel command valid |
| ch_ready | input | NCH | Per-channel command ready |
| ch_write | output | 1 | Command is a write |
| ch_addr | output | AW | In-channel word address |
| ch_wdata | output | DW | Write word for the channel |
| ch_dvalid | input | NCH | Per-channel read-data strobe |
| ch_rdata | input | NCH*DW | Read words, channel c at bits c*DW upward |

## Verification
Two functions can land in the same cycle. A verify compare can pass, which pops both queues, at the very edge where a new write is pushed into the same queues. The random phase provokes this by streaming back-to-back writes and reads while each channel's ready is withheld at random and each channel uses a different data latency. The bench model corrupts a chosen number of write attempts per request, and the count is carried in the low payload bits. Every response is judged in order against a shadow array kept by the bench, by its kind, its tag and its read word, and the total number of write attempts is compared with the sum the retry rule predicts.

// File: rtl/wv_pkg.sv
// Shared definitions for the write-verifying memory controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wv_pkg;

    // Sequencer states: one request is carried from issue to response.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_READ,
        SQ_WAIT,
        SQ_CHECK
    } seq_state_e;

    // Response kind encodings seen on rsp_kind.
    localparam logic [1:0] KIND_READ = 2'b00;
    localparam logic [1:0] KIND_WOK  = 2'b01;
    localparam logic [1:0] KIND_WERR = 2'b10;

endpackage

// File: rtl/wv_fifo.sv
// Synchronous FIFO with occupancy flags.
// Assumes the caller never pushes when full nor pops when empty.
module wv_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem_q [DEPTH];
    logic [PW-1:0]   wp_q;
    logic [PW-1:0]   rp_q;
    logic [CNTW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Entry storage, written on push.
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= din;
    end

    assign dout  = mem_q[rp_q];
    assign full  = (cnt_q == CNTW'(DEPTH));
    assign empty = (cnt_q == '0);

endmodule

// File: rtl/wv_chan_dec.sv
// Channel decoder: splits a byte address into channel index and in-channel
// word address. Assumes NCH is a power of two so the modulo is a bit slice.
module wv_chan_dec #(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int WOFF = 3,
    parameter int CW   = 2
) (
    input  logic [AW-1:0] addr,
    output logic [CW-1:0] ch_idx,
    output logic [AW-1:0] row
);
    localparam int CB = (NCH > 1) ? $clog2(NCH) : 0;

    logic [AW-1:0] word;

    assign word   = addr >> WOFF;
    assign ch_idx = CW'(word % AW'(NCH));
    assign row    = addr >> (WOFF + CB);

endmodule

// File: rtl/wv_rd_bank.sv
// Per-channel read-data registers and the read multiplexer.
// Each register loads whenever its channel strobes data, whatever the request.
module wv_rd_bank #(
    parameter int NCH = 4,
    parameter int DW  = 64,
    parameter int CW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    dvalid,
    input  logic [NCH*DW-1:0] rdata,
    input  logic [CW-1:0]     sel,
    output logic [DW-1:0]     dout,
    output logic              hit
);
    logic [DW-1:0] reg_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_reg
        // Capture the word returned on channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)         reg_q[g] <= '0;
            else if (dvalid[g]) reg_q[g] <= rdata[g*DW +: DW];
        end
    end

    assign dout = reg_q[sel];
    assign hit  = dvalid[sel];

endmodule

// File: rtl/wv_verify_seq.sv
// Request sequencer: issues the head request, performs write then read-back,
// compares, retries and emits the response. One request in flight at a time.
// Assumes the queue heads stay stable until popped.
module wv_verify_seq #(
    parameter int MAX_RETRY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aq_empty,
    input  logic       head_write,
    input  logic       ch_rdy,
    input  logic       rd_hit,
    input  logic       data_match,
    output logic       ch_go,
    output logic       ch_wr,
    output logic       aq_pop,
    output logic       wq_pop,
    output logic       rsp_valid,
    output logic [1:0] rsp_kind
);
    import wv_pkg::*;

    localparam int RCW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

    seq_state_e     state_q, state_d;
    logic [RCW-1:0] retry_q, retry_d;

    // Next-state and output decode for one request.
    always_comb begin
        state_d   = state_q;
        retry_d   = retry_q;
        ch_go     = 1'b0;
        ch_wr     = 1'b0;
        aq_pop    = 1'b0;
        wq_pop    = 1'b0;
        rsp_valid = 1'b0;
        rsp_kind  = KIND_READ;
        case (state_q)
            SQ_IDLE: begin
                if (!aq_empty) state_d = head_write ? SQ_WRITE : SQ_READ;
            end
            SQ_WRITE: begin
                ch_go = 1'b1;
                ch_wr = 1'b1;
                if (ch_rdy) state_d = SQ_READ;
            end
            SQ_READ: begin
                ch_go = 1'b1;
                if (ch_rdy) state_d = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (rd_hit) state_d = SQ_CHECK;
            end
            SQ_CHECK: begin
                if (!head_write) begin
                    rsp_valid = 1'b1;
                    aq_pop    = 1'b1;
                    state_d   = SQ_IDLE;
                end else if (data_match || retry_q == RCW'(MAX_RETRY)) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = data_match ? KIND_WOK : KIND_WERR;
                    aq_pop    = 1'b1;
                    wq_pop    = 1'b1;
                    retry_d   = '0;
                    state_d   = SQ_IDLE;
                end else begin
                    retry_d = retry_q + 1'b1;
                    state_d = SQ_WRITE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State and retry counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            retry_q <= retry_d;
        end
    end

endmodule

// File: rtl/wv_mem_ctrl.sv
// Top of the write-verifying multi-channel memory controller.
// Queues requests and write payloads, routes each request to one channel,
// verifies every write by read-back and reports the outcome per tag.
// Assumes NCH is a power of two (1..16) and DW a power of two (64..512).
module wv_mem_ctrl #(
    parameter int NCH       = 4,
    parameter int DW        = 64,
    parameter int AW        = 16,
    parameter int TW        = 4,
    parameter int AQ_DEPTH  = 4,
    parameter int WQ_DEPTH  = 2,
    parameter int MAX_RETRY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [TW-1:0]     req_tag,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [TW-1:0]     rsp_tag,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NCH-1:0]    ch_valid,
    input  logic [NCH-1:0]    ch_ready,
    output logic              ch_write,
    output logic [AW-1:0]     ch_addr,
    output logic [DW-1:0]     ch_wdata,
    input  logic [NCH-1:0]    ch_dvalid,
    input  logic [NCH*DW-1:0] ch_rdata
);
    localparam int WOFF = $clog2(DW / 8);
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int AQW  = 1 + TW + AW;

    logic           accept;
    logic [AQW-1:0] aq_head;
    logic           aq_full, aq_empty, aq_pop;
    logic [DW-1:0]  wq_head;
    logic           wq_full, wq_empty, wq_pop;
    logic           head_write;
    logic [TW-1:0]  head_tag;
    logic [AW-1:0]  head_addr;
    logic [CW-1:0]  sel;
    logic [AW-1:0]  row;
    logic [DW-1:0]  rd_word;
    logic           rd_hit;
    logic           ch_go;

    assign req_ready = !aq_full && !wq_full;
    assign accept    = req_valid && req_ready;

    wv_fifo #(.W(AQW), .DEPTH(AQ_DEPTH)) u_addr_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   ({req_write, req_tag, req_addr}),
        .pop   (aq_pop),
        .dout  (aq_head),
        .full  (aq_full),
        .empty (aq_empty)
    );

    wv_fifo #(.W(DW), .DEPTH(WQ_DEPTH)) u_wdata_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept && req_write),
        .din   (req_wdata),
        .pop   (wq_pop),
        .dout  (wq_head),
        .full  (wq_full),
        .empty (wq_empty)
    );

    assign {head_write, head_tag, head_addr} = aq_head;

    wv_chan_dec #(.NCH(NCH), .AW(AW), .WOFF(WOFF), .CW(CW)) u_dec (
        .addr   (head_addr),
        .ch_idx (sel),
        .row    (row)
    );

    wv_rd_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .dvalid (ch_dvalid),
        .rdata  (ch_rdata),
        .sel    (sel),
        .dout   (rd_word),
        .hit    (rd_hit)
    );

    wv_verify_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .aq_empty   (aq_empty),
        .head_write (head_write && !wq_empty),
        .ch_rdy     (ch_ready[sel]),
        .rd_hit     (rd_hit),
        .data_match (rd_word == wq_head),
        .ch_go      (ch_go),
        .ch_wr      (ch_write),
        .aq_pop     (aq_pop),
        .wq_pop     (wq_pop),
        .rsp_valid  (rsp_valid),
        .rsp_kind   (rsp_kind)
    );

    // Command valid demultiplexed onto the selected channel.
    for (genvar g = 0; g < NCH; g++) begin : g_vld
        assign ch_valid[g] = ch_go && (sel == CW'(g));
    end

    assign ch_addr   = row;
    assign ch_wdata  = wq_head;
    assign rsp_tag   = head_tag;
    assign rsp_rdata = rd_word;

endmodule

// File: rtl/wv_mem_ctrl_chk.sv
// Protocol checker for wv_mem_ctrl, attached by bind below.
// Assumes it observes only the top-level ports.
module wv_mem_ctrl_chk #(
    parameter int NCH       = 4,
    parameter int AW        = 16,
    parameter int AQ_DEPTH  = 4,
    parameter int MAX_RETRY = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic [1:0]     rsp_kind,
    input logic [NCH-1:0] ch_valid,
    input logic [NCH-1:0] ch_ready,
    input logic           ch_write,
    input logic [AW-1:0]  ch_addr,
    input logic [NCH-1:0] ch_dvalid
);
    logic [15:0] outst_q;
    logic [15:0] watt_q;

    // Requests accepted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= '0;
        else outst_q <= outst_q + 16'(req_valid && req_ready) - 16'(rsp_valid);
    end

    // Write attempts since the last response.
    always_ff @(posedge clk) begin
        if (!rst_n || rsp_valid) watt_q <= '0;
        else if (|(ch_valid & ch_ready) && ch_write) watt_q <= watt_q + 1'b1;
    end

    // R2
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        // R3
        cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_valid[g] && !ch_ready[g]) |=>
                (ch_valid[g] && $stable(ch_addr) && $stable(ch_write)));
    end

    // R4
    rsp_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(|ch_dvalid));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));

    // R7
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        watt_q <= 16'(MAX_RETRY + 1));

    // R9
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= 16'(AQ_DEPTH));

endmodule

bind wv_mem_ctrl wv_mem_ctrl_chk #(
    .NCH       (NCH),
    .AW        (AW),
    .AQ_DEPTH  (AQ_DEPTH),
    .MAX_RETRY (MAX_RETRY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .ch_valid  (ch_valid),
    .ch_ready  (ch_ready),
    .ch_write  (ch_write),
    .ch_addr   (ch_addr),
    .ch_dvalid (ch_dvalid)
);

// File: tb/sim_wv_mem_ctrl.sv
module sim_wv_mem_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 64;
    localparam int AW  = 16;
    localparam int TW  = 4;
    localparam int AQD = 4;
    localparam int WQD = 2;
    localparam int MXR = 2;
    localparam int ROWS = 8;
    localparam int NMAX = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [TW-1:0]     req_tag = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [TW-1:0]     rsp_tag;
    logic [DW-1:0]     rsp_rdata;
    logic [NCH-1:0]    ch_valid;
    logic [NCH-1:0]    ch_ready = '0;
    logic              ch_write;
    logic [AW-1:0]     ch_addr;
    logic [DW-1:0]     ch_wdata;
    logic [NCH-1:0]    ch_dvalid = '0;
    logic [NCH*DW-1:0] ch_rdata = '0;

    wv_mem_ctrl #(.NCH(NCH), .DW(DW), .AW(AW), .TW(TW), .AQ_DEPTH(AQD),
                  .WQ_DEPTH(WQD), .MAX_RETRY(MXR)) u0 (.*);

    initial forever #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int n_req = 0, rd_i = 0;
    int wr_hs = 0, exp_watt = 0;
    bit stall = 1'b0;
    bit done = 1'b0;

    logic [DW-1:0] mem    [NCH*ROWS];
    logic [DW-1:0] shadow [NCH*ROWS];
    logic [1:0]    exp_kind [NMAX];
    logic [DW-1:0] exp_data [NMAX];
    logic [TW-1:0] exp_tag  [NMAX];
    int            exp_ch   [NMAX];
    int            exp_row  [NMAX];

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] init_word(input int i);
        return 64'hC0DE_0000_0000_0000 | 64'(i);
    endfunction

    // Queue a request and record its expected outcome.
    task automatic push_req(input bit wr, input int ch, input int row,
                            input logic [1:0] f, input logic [2:0] boff);
        logic [DW-1:0] d;
        int idx;
        idx = ch * ROWS + row;
        d = {$urandom, $urandom};
        d[15:2] = 14'(n_req);
        d[1:0] = f;
        exp_tag[n_req] = TW'(n_req);
        exp_ch[n_req]  = ch;
        exp_row[n_req] = row;
        if (wr) begin
            if (f <= 2'(MXR)) begin
                exp_kind[n_req] = 2'b01;
                shadow[idx] = d;
            end else begin
                exp_kind[n_req] = 2'b10;
                shadow[idx] = d ^ (64'd1 << (DW - 1));
            end
            exp_watt += (f > 2'(MXR)) ? MXR + 1 : int'(f) + 1;
            exp_data[n_req] = '0;
        end else begin
            exp_kind[n_req] = 2'b00;
            exp_data[n_req] = shadow[idx];
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'((row << 5) | (ch << 3) | int'(boff));
        req_tag   = TW'(n_req);
        req_wdata = d;
        n_req++;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        while (rd_i < n_req) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Channel model: random ready, per-channel latency, injected write faults.
    initial begin
        int cnt [NCH];
        logic [DW-1:0] pend [NCH];
        bit   pw [NCH];
        logic [AW-1:0] pa [NCH];
        bit   pwr [NCH];
        logic [DW-1:0] last_key;
        int att;
        bit vpend;
        int vch;
        logic [AW-1:0] vaddr;
        for (int c = 0; c < NCH; c++) begin
            cnt[c] = 0; pw[c] = 1'b0; pend[c] = '0; pa[c] = '0; pwr[c] = 1'b0;
        end
        last_key = '1; att = 0; vpend = 1'b0; vch = 0; vaddr = '0;
        forever begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                ch_dvalid[c] = 1'b0;
                if (cnt[c] > 0) begin
                    cnt[c]--;
                    if (cnt[c] == 0) begin
                        ch_dvalid[c] = 1'b1;
                        ch_rdata[c*DW +: DW] = pend[c];
                    end
                end
                ch_ready[c] = stall ? 1'b0 : ($urandom % 4 != 0);
            end
            #1;
            for (int c = 0; c < NCH; c++) begin
                if (rst_n && pw[c]) begin
                    // R3 command held until accepted
                    chk(ch_valid[c] && ch_addr == pa[c] && ch_write == pwr[c],
                        "R3 command hold", 64'(ch_addr), 64'(pa[c]));
                end
                pw[c] = ch_valid[c] && !ch_ready[c];
                pa[c] = ch_addr;
                pwr[c] = ch_write;
                if (ch_valid[c] && ch_ready[c]) begin
                    int idx;
                    idx = c * ROWS + int'(ch_addr[2:0]);
                    // R2 channel and in-channel address decode
                    chk(c == exp_ch[rd_i] && ch_addr == AW'(exp_row[rd_i]),
                        "R2 channel decode", 64'(c * 65536 + int'(ch_addr)),
                        64'(exp_ch[rd_i] * 65536 + exp_row[rd_i]));
                    if (ch_write) begin
                        // R5 no second write before the read-back
                        chk(!vpend, "R5 write without read-back", 64'(vpend), 64'd0);
                        wr_hs++;
                        if (ch_wdata != last_key) begin
                            last_key = ch_wdata;
                            att = 0;
                        end
                        if (att < int'(ch_wdata[1:0]))
                            mem[idx] = ch_wdata ^ (64'd1 << (DW - 1));
                        else
                            mem[idx] = ch_wdata;
                        att++;
                        vpend = 1'b1; vch = c; vaddr = ch_addr;
                    end else begin
                        if (vpend) begin
                            // R5 read-back targets the written location
                            chk(c == vch && ch_addr == vaddr, "R5 read-back target",
                                64'(ch_addr), 64'(vaddr));
                            vpend = 1'b0;
                        end
                        pend[c] = mem[idx];
                        cnt[c] = c + 1;
                    end
                end
            end
        end
    end

    // Response monitor: in-order comparison with the expected records.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (rd_i >= n_req) begin
                    chk(1'b0, "R4 unexpected response", 64'(rsp_tag), 64'd0);
                end else begin
                    chk(rsp_tag == exp_tag[rd_i], "R4 tag echo",
                        64'(rsp_tag), 64'(exp_tag[rd_i]));
                    case (exp_kind[rd_i])
                        2'b01: chk(rsp_kind == 2'b01, "R6 verified kind",
                                   64'(rsp_kind), 64'd1);
                        2'b10: chk(rsp_kind == 2'b10, "R8 error kind",
                                   64'(rsp_kind), 64'd2);
                        default: begin
                            chk(rsp_kind == 2'b00, "R4 read kind", 64'(rsp_kind), 64'd0);
                            chk(rsp_rdata == exp_data[rd_i], "R4 R10 read data",
                                rsp_rdata, exp_data[rd_i]);
                        end
                    endcase
                    rd_i++;
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 64'(rd_i), 64'(n_req));
            finish_run();
        end
    end

    // Stimulus.
    initial begin
        void'($urandom(32'd11));
        for (int i = 0; i < NCH * ROWS; i++) begin
            mem[i] = init_word(i);
            shadow[i] = init_word(i);
        end
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 rsp idle in reset", 64'(rsp_valid), 64'd0);
        chk(ch_valid == '0, "R1 channels idle in reset", 64'(ch_valid), 64'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && ch_valid == '0 && rsp_valid == 1'b0,
            "R1 state after reset", 64'(req_ready), 64'd1);

        // R9 write-data queue fills first
        stall = 1'b1;
        push_req(1'b1, 1, 2, 2'd0, 3'd0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 one write queued", 64'(req_ready), 64'd1);
        push_req(1'b1, 2, 3, 2'd0, 3'd0);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 write queue full", 64'(req_ready), 64'd0);
        stall = 1'b0;
        drain();

        // R9 address queue fills with reads
        stall = 1'b1;
        for (int i = 0; i < AQD - 1; i++) push_req(1'b0, i % NCH, 1, 2'd0, 3'd5);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 address queue one short", 64'(req_ready), 64'd1);
        push_req(1'b0, 3, 7, 2'd0, 3'd7);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 address queue full", 64'(req_ready), 64'd0);
        stall = 1'b0;
        drain();

        // R6 R7 R8 R10 fault counts 0..3 on one location, each read back
        for (int f = 0; f < 4; f++) begin
            push_req(1'b1, 3, 5, 2'(f), 3'd0);
            push_req(1'b0, 3, 5, 2'd0, 3'd2);
        end
        drain();

        // Random mix, back-to-back.
        for (int i = 0; i < 300; i++) begin
            int r;
            logic [1:0] f;
            r = $urandom % 10;
            f = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
            push_req(1'($urandom % 2), $urandom % NCH, $urandom % ROWS, f,
                     3'($urandom % 8));
        end
        drain();
        repeat (10) @(negedge clk);

        // R7 total write attempts match the retry rule
        chk(wr_hs == exp_watt, "R7 write attempt count", 64'(wr_hs), 64'(exp_watt));
        chk(rd_i == n_req, "R4 every request answered", 64'(rd_i), 64'(n_req));
        done = 1'b1;
        finish_run();
    end

endmodule